// File: doc/BRIEF.md
# Colour Palette Loader

This block holds a 256-entry colour lookup table and loads it through a small 32-bit register window. Software first writes the entry number to an index register. It then writes the three colour components to a data register, one component per write, in the order red, green, blue. Each component is taken from the most significant byte of the written word. The blue write commits the whole entry into the table and moves the index on to the next entry, so a run of data writes fills consecutive entries without further index writes.

A pixel pipeline uses a separate lookup port. It presents one 8-bit index per cycle and receives the 24-bit colour on the next clock edge. The lookup port never stalls.

The register side is a valid/ready request channel. `req_ready` is low while the table is being cleared after reset, and high from then on. A request is taken only in a cycle where both `req_valid` and `req_ready` are high, and the host must hold the request stable until that happens. Reads are accepted but the window has nothing to read back.

Top module: `clut_loader`

## Requirements
- R1: For exactly 256 cycles after reset is released, `req_ready` is low while the table is cleared. It is then high and stays high until the next reset. During reset, `resp_valid` and `lk_rvalid` are low.
- R2: Once `req_ready` has risen, entries 0 to 254 read back as 0x000000 and entry 255 reads back as 0xFFFFFF. The lookup result is packed as red in bits 23:16, green in bits 15:8 and blue in bits 7:0.
- R3: An accepted full-word write to byte offset 0 does two things. It loads the current index from bits 31:24 of the write data, and it returns the component sequence to red.
- R4: Accepted full-word writes to byte offset 4 take bits 31:24 as red, then green, then blue. The entry is written into the table only on the blue write. Until then, a lookup of that entry returns its previous colour.
- R5: After each blue write the index advances by one, modulo 256, so entry 255 is followed by entry 0. The sequence returns to red.
- R6: The following writes change neither the table, the index nor the sequence: writes to offset 8 or 12, writes to an address that is not a multiple of 4, and writes whose byte enables are not all ones.
- R7: An accepted read produces `resp_valid` high in the next cycle, with `resp_rdata` equal to zero. Writes produce no response.
- R8: A lookup with `lk_valid` high returns `lk_rvalid` high and the entry's colour on the next clock edge. If a blue write commits the same entry in that cycle, the lookup returns the previous colour, and the new colour is returned from the following cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Register request valid |
| req_ready | output | 1 | Register request ready (low during table clear) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 4 | Byte offset within the 16-byte window |
| req_wdata | input | 32 | Write data; bits 31:24 carry the index or the component |
| req_be | input | 4 | Byte enables; only 4'b1111 is acted upon |
| resp_valid | output | 1 | Read response valid |
| resp_rdata | output | 32 | Read response data, always zero |
| lk_valid | input | 1 | Lookup request valid |
| lk_idx | input | 8 | Entry to look up |
| lk_rvalid | output | 1 | Lookup result valid |
| lk_rgb | output | 24 | Looked-up colour {red, green, blue} |

## Verification
The bench loads every entry through a single index write followed by 768 data writes. It then sweeps the whole table. This catches a design that steps the index on every component, or that skips the index step.

A short load starting at entry 254 exercises the wrap of the index. A wrong wrap would leave entry 0 untouched, or would write into entry 1.

An index write issued after only two components must discard those components. A design that keeps them would place the wrong colour into the new entry.

Writes to unused offsets, misaligned writes and partial-byte writes are each followed by a normal red, green, blue sequence. A design that lets any of them advance the sequence would store shifted colours.

A lookup issued in the same cycle as the blue write must return the old colour. A design with a write-forwarding path would return the new colour one cycle early.

// File: rtl/clut_pkg.sv
package clut_pkg;
  typedef enum logic [1:0] {
    SEQ_RED = 2'd0,
    SEQ_GRN = 2'd1,
    SEQ_BLU = 2'd2
  } seq_e;
endpackage

// File: rtl/clut_init.sv
module clut_init #(
  parameter int ENTRIES = 256,
  parameter int IDX_W   = 8,
  parameter int RGB_W   = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic             busy,
  output logic             init_we,
  output logic [IDX_W-1:0] init_idx,
  output logic [RGB_W-1:0] init_rgb
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic [IDX_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      busy <= 1'b1;
    end else if (busy) begin
      if (cnt == LAST) busy <= 1'b0;
      else             cnt  <= cnt + 1'b1;
    end
  end

  assign init_we  = busy;
  assign init_idx = cnt;
  assign init_rgb = (cnt == LAST) ? {RGB_W{1'b1}} : '0;
endmodule

// File: rtl/clut_regif.sv
module clut_regif
  import clut_pkg::*;
#(
  parameter int BUS_W   = 32,
  parameter int AW      = 4,
  parameter int IDX_W   = 8,
  parameter int COMP_W  = 8,
  parameter int IDX_OFF = 0,
  parameter int DAT_OFF = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_acc,
  input  logic [AW-1:0]       addr,
  input  logic [BUS_W-1:0]    wdata,
  input  logic [BUS_W/8-1:0]  be,
  output logic                cm_we,
  output logic [IDX_W-1:0]    cm_idx,
  output logic [3*COMP_W-1:0] cm_rgb
);
  logic              full_word;
  logic              hit_idx;
  logic              hit_dat;
  logic [COMP_W-1:0] comp;
  logic [IDX_W-1:0]  new_idx;
  seq_e              seq;
  logic [IDX_W-1:0]  idx;
  logic [COMP_W-1:0] red_q;
  logic [COMP_W-1:0] grn_q;
  logic              unused_low_bits;

  assign full_word = &be;
  assign hit_idx   = wr_acc && full_word && (addr == AW'(IDX_OFF));
  assign hit_dat   = wr_acc && full_word && (addr == AW'(DAT_OFF));
  assign comp      = wdata[BUS_W-1 -: COMP_W];
  assign new_idx   = wdata[BUS_W-1 -: IDX_W];
  assign unused_low_bits = ^wdata[BUS_W-COMP_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seq   <= SEQ_RED;
      idx   <= '0;
      red_q <= '0;
      grn_q <= '0;
    end else if (hit_idx) begin
      idx <= new_idx;
      seq <= SEQ_RED;
    end else if (hit_dat) begin
      unique case (seq)
        SEQ_RED: begin
          red_q <= comp;
          seq   <= SEQ_GRN;
        end
        SEQ_GRN: begin
          grn_q <= comp;
          seq   <= SEQ_BLU;
        end
        default: begin
          idx <= idx + 1'b1;
          seq <= SEQ_RED;
        end
      endcase
    end
  end

  assign cm_we  = hit_dat && (seq == SEQ_BLU);
  assign cm_idx = idx;
  assign cm_rgb = {red_q, grn_q, comp};
endmodule

// File: rtl/clut_store.sv
module clut_store #(
  parameter int ENTRIES = 256,
  parameter int IDX_W   = 8,
  parameter int RGB_W   = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  logic [RGB_W-1:0] wrgb,
  input  logic             lk_valid,
  input  logic [IDX_W-1:0] lk_idx,
  output logic             lk_rvalid,
  output logic [RGB_W-1:0] lk_rgb
);
  logic [RGB_W-1:0] mem [ENTRIES];

  always_ff @(posedge clk) begin
    if (we) mem[widx] <= wrgb;
    if (lk_valid) lk_rgb <= mem[lk_idx];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) lk_rvalid <= 1'b0;
    else        lk_rvalid <= lk_valid;
  end
endmodule

// File: rtl/clut_loader.sv
module clut_loader #(
  parameter int ENTRIES   = 256,
  parameter int COMP_W    = 8,
  parameter int BUS_W     = 32,
  parameter int WIN_BYTES = 16,
  parameter int IDX_OFF   = 0,
  parameter int DAT_OFF   = 4,
  localparam int AW       = $clog2(WIN_BYTES),
  localparam int IDX_W    = $clog2(ENTRIES),
  localparam int RGB_W    = 3 * COMP_W,
  localparam int BE_W     = BUS_W / 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [AW-1:0]    req_addr,
  input  logic [BUS_W-1:0] req_wdata,
  input  logic [BE_W-1:0]  req_be,
  output logic             resp_valid,
  output logic [BUS_W-1:0] resp_rdata,
  input  logic             lk_valid,
  input  logic [IDX_W-1:0] lk_idx,
  output logic             lk_rvalid,
  output logic [RGB_W-1:0] lk_rgb
);
  logic             busy;
  logic             init_we;
  logic [IDX_W-1:0] init_idx;
  logic [RGB_W-1:0] init_rgb;
  logic             cm_we;
  logic [IDX_W-1:0] cm_idx;
  logic [RGB_W-1:0] cm_rgb;
  logic             acc;
  logic             st_we;
  logic [IDX_W-1:0] st_idx;
  logic [RGB_W-1:0] st_rgb;

  assign req_ready = !busy;
  assign acc       = req_valid && req_ready;

  clut_init #(.ENTRIES(ENTRIES), .IDX_W(IDX_W), .RGB_W(RGB_W)) u_init (
    .clk(clk), .rst_n(rst_n), .busy(busy),
    .init_we(init_we), .init_idx(init_idx), .init_rgb(init_rgb)
  );

  clut_regif #(
    .BUS_W(BUS_W), .AW(AW), .IDX_W(IDX_W), .COMP_W(COMP_W),
    .IDX_OFF(IDX_OFF), .DAT_OFF(DAT_OFF)
  ) u_regif (
    .clk(clk), .rst_n(rst_n), .wr_acc(acc && req_write),
    .addr(req_addr), .wdata(req_wdata), .be(req_be),
    .cm_we(cm_we), .cm_idx(cm_idx), .cm_rgb(cm_rgb)
  );

  // The clear sweep and host commits never overlap: commits need req_ready.
  assign st_we  = init_we | cm_we;
  assign st_idx = init_we ? init_idx : cm_idx;
  assign st_rgb = init_we ? init_rgb : cm_rgb;

  clut_store #(.ENTRIES(ENTRIES), .IDX_W(IDX_W), .RGB_W(RGB_W)) u_store (
    .clk(clk), .rst_n(rst_n), .we(st_we), .widx(st_idx), .wrgb(st_rgb),
    .lk_valid(lk_valid), .lk_idx(lk_idx),
    .lk_rvalid(lk_rvalid), .lk_rgb(lk_rgb)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) resp_valid <= 1'b0;
    else        resp_valid <= acc && !req_write;
  end

  assign resp_rdata = '0;
endmodule

// File: rtl/clut_loader_chk.sv
module clut_loader_chk #(
  parameter int BUS_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             req_write,
  input logic             resp_valid,
  input logic [BUS_W-1:0] resp_rdata,
  input logic             lk_valid,
  input logic             lk_rvalid
);
  a_r1_ready_low_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !req_ready);

  a_r1_ready_holds: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |=> req_ready);

  a_r7_read_resp: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_write) |=> (resp_valid && resp_rdata == '0));

  a_r7_no_spurious_resp: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_ready && !req_write) |=> !resp_valid);

  a_r8_lookup_latency: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> lk_rvalid);

  a_r8_no_spurious_rvalid: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !lk_rvalid);
endmodule

bind clut_loader clut_loader_chk #(.BUS_W(BUS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .resp_valid(resp_valid), .resp_rdata(resp_rdata),
  .lk_valid(lk_valid), .lk_rvalid(lk_rvalid)
);

// File: tb/sim_clut_loader.sv
`timescale 1ns/1ps
module sim_clut_loader;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [3:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [3:0]  req_be = '0;
  logic        resp_valid;
  logic [31:0] resp_rdata;
  logic        lk_valid = 1'b0;
  logic [7:0]  lk_idx = '0;
  logic        lk_rvalid;
  logic [23:0] lk_rgb;

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [23:0] exp_tab [256];

  always #2.5 clk = ~clk;

  clut_loader u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_be(req_be), .resp_valid(resp_valid), .resp_rdata(resp_rdata),
    .lk_valid(lk_valid), .lk_idx(lk_idx), .lk_rvalid(lk_rvalid), .lk_rgb(lk_rgb)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d; req_be = be;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic set_idx(input logic [7:0] i);
    wr(4'h0, {i, 24'h5A5A5A}, 4'hF);
  endtask

  task automatic put(input logic [7:0] c);
    wr(4'h4, {c, 24'hA5A5A5}, 4'hF);
  endtask

  task automatic look(input logic [7:0] i, input string req, input logic [23:0] exp);
    @(negedge clk);
    lk_valid = 1'b1; lk_idx = i;
    @(negedge clk);
    lk_valid = 1'b0;
    check(req, {7'd0, lk_rvalid, lk_rgb}, {8'h01, exp});
  endtask

  function automatic logic [23:0] pat(input int i);
    logic [7:0] r = 8'(i * 7 + 3);
    logic [7:0] g = 8'(i) ^ 8'h5A;
    logic [7:0] b = 8'(255 - i);
    return {r, g, b};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    int low_cycles;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 reset outputs", {29'd0, req_ready, resp_valid, lk_rvalid}, 32'd0);
    rst_n = 1'b1;
    low_cycles = 0;
    @(negedge clk);
    while (!req_ready && low_cycles < 1000) begin
      low_cycles++;
      @(negedge clk);
    end
    low_cycles++;
    check("R1 clear duration", low_cycles, 256);
    repeat (5) @(negedge clk);
    check("R1 ready stays high", {31'd0, req_ready}, 32'd1);

    // R2: reset contents
    for (int i = 0; i < 256; i++) begin
      exp_tab[i] = (i == 255) ? 24'hFFFFFF : 24'h000000;
      look(8'(i), "R2 reset content", exp_tab[i]);
    end

    // R7: read returns zero one cycle later
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 4'h4;
    @(negedge clk);
    req_valid = 1'b0;
    check("R7 read response", {resp_valid, resp_rdata[30:0]}, 32'h80000000);
    check("R7 read data top bit", {31'd0, resp_rdata[31]}, 32'd0);
    @(negedge clk);
    check("R7 single response", {31'd0, resp_valid}, 32'd0);

    // R3 R5: full load through auto-increment
    set_idx(8'd0);
    for (int i = 0; i < 256; i++) begin
      exp_tab[i] = pat(i);
      put(exp_tab[i][23:16]);
      put(exp_tab[i][15:8]);
      put(exp_tab[i][7:0]);
    end
    for (int i = 0; i < 256; i++) look(8'(i), "R5 sequential load", exp_tab[i]);

    // R5: wrap from 255 to 0
    set_idx(8'd254);
    for (int k = 0; k < 3; k++) begin
      exp_tab[(254 + k) % 256] = 24'h102030 + 24'(k * 24'h010101);
      put(exp_tab[(254 + k) % 256][23:16]);
      put(exp_tab[(254 + k) % 256][15:8]);
      put(exp_tab[(254 + k) % 256][7:0]);
    end
    look(8'd254, "R5 wrap 254", exp_tab[254]);
    look(8'd255, "R5 wrap 255", exp_tab[255]);
    look(8'd0,   "R5 wrap 0", exp_tab[0]);
    look(8'd1,   "R5 wrap leaves 1", exp_tab[1]);

    // R3: index write mid-sequence restarts at red
    set_idx(8'd10);
    put(8'hDE); put(8'hAD);
    set_idx(8'd20);
    put(8'h12); put(8'h34); put(8'h56);
    exp_tab[20] = 24'h123456;
    look(8'd10, "R3 abandoned entry", exp_tab[10]);
    look(8'd20, "R3 restarted entry", exp_tab[20]);

    // R6: ignored writes
    set_idx(8'd30);
    wr(4'h8, 32'hEE000000, 4'hF);
    wr(4'hC, 32'hEE000000, 4'hF);
    wr(4'h5, 32'hEE000000, 4'hF);
    wr(4'h4, 32'hEE000000, 4'h7);
    wr(4'h4, 32'hEE000000, 4'hE);
    wr(4'h1, 32'h80000000, 4'hF);
    put(8'h11); put(8'h22); put(8'h33);
    exp_tab[30] = 24'h112233;
    look(8'd30, "R6 ignored writes", exp_tab[30]);
    look(8'd31, "R6 neighbour intact", exp_tab[31]);

    // R4 R8: partial entry invisible, same-cycle lookup sees old value
    set_idx(8'd40);
    put(8'hC1); put(8'hC2);
    look(8'd40, "R4 before blue", exp_tab[40]);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 4'h4;
    req_wdata = 32'hC3000000; req_be = 4'hF;
    lk_valid = 1'b1; lk_idx = 8'd40;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; lk_valid = 1'b0;
    check("R8 same-cycle old value", {7'd0, lk_rvalid, lk_rgb}, {8'h01, exp_tab[40]});
    exp_tab[40] = 24'hC1C2C3;
    look(8'd40, "R8 new value next", exp_tab[40]);
    // R5: index moved to 41 after blue
    put(8'h41); put(8'h42); put(8'h43);
    look(8'd41, "R5 increment after blue", 24'h414243);
    @(negedge clk);
    check("R8 rvalid drops", {31'd0, lk_rvalid}, 32'd0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule